// File: doc/BRIEF.md
# Instruction-Level Energy Accumulator

This block is a profiling unit that sits next to a processor's retire port and builds up an estimate of the energy used by the program. Each retiring instruction comes with a 3-bit class code and two flags: one for a cache miss and one for a pipeline stall. On every qualified retire, the block adds several costs to a saturating total:

- a per-class base cost;
- a transition cost chosen by the previous class and the current class;
- a separate cost for each flag that is raised.

The block also keeps one execution count per class and one count per ordered class pair.

Cost values are loaded through a simple write port. That port uses one flat address space that covers the pair table, the base table and the two effect costs. Software or a test harness loads the costs once. It then lets the program run, and reads the total and any counter through select inputs. Those select inputs drive combinational read-out ports. A clear input restarts a measurement window in one cycle and keeps the loaded costs.

Top module: `energy_profiler`

## Requirements
- R1: On a cycle with `ret_valid_i` high and `clear_i` low, the base cost of the class on `ret_class_i` is added to `energy_o`, visible after that clock edge.
- R2: When a retire has a predecessor, the transition cost at pair-table address prev*8+cur (addresses 0 to 63) is also added, once per retire.
- R3: The first retire after reset or after a clear has no predecessor and adds no transition cost.
- R4: A raised `ret_miss_i` adds the miss cost (address 72), and a raised `ret_stall_i` adds the stall cost (address 73). The two flags act independently of each other and of the class.
- R5: Each retire increments the execution count of its class, readable on `cls_count_o` with `cls_sel_i` selecting the class.
- R6: Each retire that has a predecessor increments the pair count at index prev*8+cur, readable on `pair_count_o` with `pair_sel_i` selecting the index. The first retire of a window counts no pair.
- R7: `energy_o` saturates at all ones (2^ACC_W-1) and never wraps or decreases except on clear.
- R8: A cycle without `ret_valid_i` changes neither the total nor any count nor the remembered predecessor.
- R9: `clear_i` zeroes the total and all counts and forgets the predecessor in one cycle. A retire in the same cycle is dropped, and the cost tables keep their contents.
- R10: A write with `cfg_we_i` stores `cfg_data_i` at `cfg_addr_i`, where base costs sit at 64+class. A retire in the same cycle still uses the old cost, and writes to addresses 74 to 127 change no cost.
- R11: After reset the total, all counts and all costs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Restart the measurement window |
| ret_valid_i | input | 1 | A retiring instruction is present |
| ret_class_i | input | CLS_W | Class of the retiring instruction |
| ret_miss_i | input | 1 | Retiring instruction saw a cache miss |
| ret_stall_i | input | 1 | Retiring instruction saw a pipeline stall |
| cfg_we_i | input | 1 | Cost write enable |
| cfg_addr_i | input | 2*CLS_W+1 | Cost write address |
| cfg_data_i | input | COST_W | Cost write value |
| cls_sel_i | input | CLS_W | Class whose count is shown |
| pair_sel_i | input | 2*CLS_W | Pair index whose count is shown |
| energy_o | output | ACC_W | Accumulated energy |
| cls_count_o | output | CNT_W | Execution count of the selected class |
| pair_count_o | output | CNT_W | Count of the selected class pair |

## Verification
The properties assume that reset is asserted before the first edge and that `clear_i`, `ret_valid_i` and the energy output are sampled only in cycles where reset is released. Within those cycles they rely on the total moving only upward, except through clear. The stimulus respects this by holding reset over several edges and by changing every input at the falling edge. The bench narrows the accumulator to 20 bits so that saturation is reached within a handful of retires of large costs. This exercises the ceiling without leaving the legal cost range.

// File: rtl/ep_pkg.sv
package ep_pkg;

    // Which cost store a configuration write lands in
    typedef enum logic [1:0] {
        TGT_PAIR  = 2'd0,
        TGT_BASE  = 2'd1,
        TGT_EXTRA = 2'd2,
        TGT_NONE  = 2'd3
    } cfg_tgt_e;

    // Slots of the effect-cost store
    localparam int unsigned EXTRA_MISS  = 0;
    localparam int unsigned EXTRA_STALL = 1;
    localparam int unsigned EXTRA_SLOTS = 2;

endpackage

// File: rtl/ep_cost_table.sv
module ep_cost_table #(
    parameter  int DEPTH = 8,
    parameter  int W     = 16,
    parameter  int NRD   = 1,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i [NRD],
    output logic [W-1:0]  rdata_o [NRD]
);

    logic [W-1:0] entry_all [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [W-1:0] val_d;
        logic [W-1:0] val_q;

        always_comb begin
            val_d = val_q;
            if (we_i && (waddr_i == AW'(g))) begin
                val_d = wdata_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                val_q <= '0;
            end else begin
                val_q <= val_d;
            end
        end

        assign entry_all[g] = val_q;
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata_o[r] = entry_all[raddr_i[r]];
    end

endmodule

// File: rtl/ep_counter_bank.sv
module ep_counter_bank #(
    parameter  int N  = 8,
    parameter  int W  = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          inc_i,
    input  logic [IW-1:0] inc_idx_i,
    input  logic [IW-1:0] sel_i,
    output logic [W-1:0]  cnt_o
);

    logic [W-1:0] cnt_all [N];

    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic [W-1:0] cnt_d;
        logic [W-1:0] cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (clear_i) begin
                cnt_d = '0;
            end else if (inc_i && (inc_idx_i == IW'(g))) begin
                cnt_d = cnt_q + 1'b1;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign cnt_all[g] = cnt_q;
    end

    assign cnt_o = cnt_all[sel_i];

endmodule

// File: rtl/ep_energy_sum.sv
module ep_energy_sum #(
    parameter  int ACC_W  = 48,
    parameter  int COST_W = 16,
    localparam int SW     = ACC_W + 1
) (
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [COST_W-1:0] base_i,
    input  logic [COST_W-1:0] pair_i,
    input  logic [COST_W-1:0] miss_cost_i,
    input  logic [COST_W-1:0] stall_cost_i,
    input  logic              pair_en_i,
    input  logic              miss_en_i,
    input  logic              stall_en_i,
    output logic [ACC_W-1:0]  sum_o
);

    localparam logic [SW-1:0] LIMIT = {1'b0, {ACC_W{1'b1}}};

    logic [SW-1:0] terms;
    logic [SW-1:0] total;

    always_comb begin
        terms = SW'(base_i);
        if (pair_en_i) begin
            terms = terms + SW'(pair_i);
        end
        if (miss_en_i) begin
            terms = terms + SW'(miss_cost_i);
        end
        if (stall_en_i) begin
            terms = terms + SW'(stall_cost_i);
        end
        total = {1'b0, acc_i} + terms;
        sum_o = (total > LIMIT) ? {ACC_W{1'b1}} : total[ACC_W-1:0];
    end

endmodule

// File: rtl/energy_profiler.sv
module energy_profiler
    import ep_pkg::*;
#(
    parameter  int CLS_W  = 3,
    parameter  int COST_W = 16,
    parameter  int ACC_W  = 48,
    parameter  int CNT_W  = 32,
    localparam int NCLS   = 1 << CLS_W,
    localparam int PAIR_W = 2 * CLS_W,
    localparam int NPAIR  = 1 << PAIR_W,
    localparam int CFG_AW = PAIR_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              ret_valid_i,
    input  logic [CLS_W-1:0]  ret_class_i,
    input  logic              ret_miss_i,
    input  logic              ret_stall_i,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [COST_W-1:0] cfg_data_i,
    input  logic [CLS_W-1:0]  cls_sel_i,
    input  logic [PAIR_W-1:0] pair_sel_i,
    output logic [ACC_W-1:0]  energy_o,
    output logic [CNT_W-1:0]  cls_count_o,
    output logic [CNT_W-1:0]  pair_count_o
);

    typedef struct packed {
        logic [ACC_W-1:0] energy;
        logic [CLS_W-1:0] prev;
        logic             has_prev;
    } state_t;

    state_t state_d;
    state_t state_q;

    // ---------------- configuration decode ----------------
    cfg_tgt_e          cfg_tgt;
    logic [CLS_W-1:0]  cfg_region;

    always_comb begin
        cfg_region = cfg_addr_i[PAIR_W-1:CLS_W];
        cfg_tgt    = TGT_NONE;
        if (!cfg_addr_i[CFG_AW-1]) begin
            cfg_tgt = TGT_PAIR;
        end else if (cfg_region == '0) begin
            cfg_tgt = TGT_BASE;
        end else if ((cfg_region == CLS_W'(1)) && (cfg_addr_i[CLS_W-1:1] == '0)) begin
            cfg_tgt = TGT_EXTRA;
        end
    end

    logic pair_we;
    logic base_we;
    logic extra_we;

    assign pair_we  = cfg_we_i && (cfg_tgt == TGT_PAIR);
    assign base_we  = cfg_we_i && (cfg_tgt == TGT_BASE);
    assign extra_we = cfg_we_i && (cfg_tgt == TGT_EXTRA);

    // ---------------- cost stores ----------------
    logic [PAIR_W-1:0] pair_idx;
    logic [PAIR_W-1:0] pair_raddr [1];
    logic [COST_W-1:0] pair_rdata [1];
    logic [CLS_W-1:0]  base_raddr [1];
    logic [COST_W-1:0] base_rdata [1];
    logic [0:0]        extra_raddr [EXTRA_SLOTS];
    logic [COST_W-1:0] extra_rdata [EXTRA_SLOTS];

    assign pair_idx      = {state_q.prev, ret_class_i};
    assign pair_raddr[0] = pair_idx;
    assign base_raddr[0] = ret_class_i;

    for (genvar s = 0; s < EXTRA_SLOTS; s++) begin : g_extra_rd
        assign extra_raddr[s] = 1'(s);
    end

    ep_cost_table #(
        .DEPTH (NPAIR),
        .W     (COST_W),
        .NRD   (1)
    ) u_pair_tab (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (pair_we),
        .waddr_i (cfg_addr_i[PAIR_W-1:0]),
        .wdata_i (cfg_data_i),
        .raddr_i (pair_raddr),
        .rdata_o (pair_rdata)
    );

    ep_cost_table #(
        .DEPTH (NCLS),
        .W     (COST_W),
        .NRD   (1)
    ) u_base_tab (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (base_we),
        .waddr_i (cfg_addr_i[CLS_W-1:0]),
        .wdata_i (cfg_data_i),
        .raddr_i (base_raddr),
        .rdata_o (base_rdata)
    );

    ep_cost_table #(
        .DEPTH (EXTRA_SLOTS),
        .W     (COST_W),
        .NRD   (EXTRA_SLOTS)
    ) u_extra_tab (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (extra_we),
        .waddr_i (cfg_addr_i[0]),
        .wdata_i (cfg_data_i),
        .raddr_i (extra_raddr),
        .rdata_o (extra_rdata)
    );

    // ---------------- energy sum ----------------
    logic [ACC_W-1:0] energy_next;

    ep_energy_sum #(
        .ACC_W  (ACC_W),
        .COST_W (COST_W)
    ) u_sum (
        .acc_i        (state_q.energy),
        .base_i       (base_rdata[0]),
        .pair_i       (pair_rdata[0]),
        .miss_cost_i  (extra_rdata[EXTRA_MISS]),
        .stall_cost_i (extra_rdata[EXTRA_STALL]),
        .pair_en_i    (state_q.has_prev),
        .miss_en_i    (ret_miss_i),
        .stall_en_i   (ret_stall_i),
        .sum_o        (energy_next)
    );

    // ---------------- counters ----------------
    logic retire;
    logic pair_inc;

    assign retire   = ret_valid_i && !clear_i;
    assign pair_inc = retire && state_q.has_prev;

    ep_counter_bank #(
        .N (NCLS),
        .W (CNT_W)
    ) u_cls_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (clear_i),
        .inc_i     (retire),
        .inc_idx_i (ret_class_i),
        .sel_i     (cls_sel_i),
        .cnt_o     (cls_count_o)
    );

    ep_counter_bank #(
        .N (NPAIR),
        .W (CNT_W)
    ) u_pair_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (clear_i),
        .inc_i     (pair_inc),
        .inc_idx_i (pair_idx),
        .sel_i     (pair_sel_i),
        .cnt_o     (pair_count_o)
    );

    // ---------------- accumulator state ----------------
    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            state_d.energy   = '0;
            state_d.prev     = '0;
            state_d.has_prev = 1'b0;
        end else if (ret_valid_i) begin
            state_d.energy   = energy_next;
            state_d.prev     = ret_class_i;
            state_d.has_prev = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign energy_o = state_q.energy;

endmodule

// File: rtl/ep_checker.sv
module ep_checker #(
    parameter int ACC_W = 48
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             clear_i,
    input logic             ret_valid_i,
    input logic [ACC_W-1:0] energy_o
);

    localparam logic [ACC_W-1:0] EMAX = {ACC_W{1'b1}};

    AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (energy_o == '0)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ret_valid_i && !clear_i) |=> $stable(energy_o)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear_i |=> (energy_o >= $past(energy_o))); // R7

    AST_SAT_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((energy_o == EMAX) && ret_valid_i && !clear_i) |=> (energy_o == EMAX)); // R7

endmodule

bind energy_profiler ep_checker #(
    .ACC_W (ACC_W)
) i_ep_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .ret_valid_i (ret_valid_i),
    .energy_o    (energy_o)
);

// File: tb/test_energy_profiler.sv
`timescale 1ns/1ps
module test_energy_profiler;

    localparam int     ACC_W = 20;
    localparam longint EMAX  = (64'd1 << ACC_W) - 1;
    localparam int     A_BASE  = 64;
    localparam int     A_MISS  = 72;
    localparam int     A_STALL = 73;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        clear = 1'b0;
    logic        rv = 1'b0;
    logic [2:0]  rcls = '0;
    logic        rmiss = 1'b0;
    logic        rstall = 1'b0;
    logic        we = 1'b0;
    logic [6:0]  waddr = '0;
    logic [15:0] wdata = '0;
    logic [2:0]  csel = '0;
    logic [5:0]  psel = '0;
    logic [ACC_W-1:0] energy;
    logic [31:0] ccount;
    logic [31:0] pcount;

    always #2 clk = ~clk;

    energy_profiler #(.ACC_W(ACC_W)) i_energy_profiler (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .clear_i      (clear),
        .ret_valid_i  (rv),
        .ret_class_i  (rcls),
        .ret_miss_i   (rmiss),
        .ret_stall_i  (rstall),
        .cfg_we_i     (we),
        .cfg_addr_i   (waddr),
        .cfg_data_i   (wdata),
        .cls_sel_i    (csel),
        .pair_sel_i   (psel),
        .energy_o     (energy),
        .cls_count_o  (ccount),
        .pair_count_o (pcount)
    );

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    bit     done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // reference model
    longint m_e = 0;
    int     m_prev = 0;
    bit     m_has = 1'b0;
    longint m_base [8];
    longint m_pair [64];
    longint m_miss = 0;
    longint m_stall = 0;
    int     m_ccnt [8];
    int     m_pcnt [64];

    typedef struct {
        longint due;
        longint val;
        string  tag;
    } exp_t;
    exp_t exp_q [$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, model update, expected item queued
    task automatic step(input bit v, input int c, input bit mi, input bit st,
                        input bit w, input int a, input int d, input bit clr,
                        input string tag);
        longint add;
        @(negedge clk);
        rv = v; rcls = 3'(c); rmiss = mi; rstall = st;
        we = w; waddr = 7'(a); wdata = 16'(d); clear = clr;
        if (clr) begin
            m_e = 0; m_has = 1'b0; m_prev = 0;
            for (int i = 0; i < 8; i++) m_ccnt[i] = 0;
            for (int i = 0; i < 64; i++) m_pcnt[i] = 0;
        end else if (v) begin
            add = m_base[c];
            if (m_has) begin
                add += m_pair[m_prev * 8 + c];
                m_pcnt[m_prev * 8 + c]++;
            end
            if (mi) add += m_miss;
            if (st) add += m_stall;
            m_e = (m_e + add > EMAX) ? EMAX : m_e + add;
            m_ccnt[c]++;
            m_prev = c;
            m_has = 1'b1;
        end
        if (w) begin
            if (a < 64) m_pair[a] = d;
            else if (a < 72) m_base[a - 64] = d;
            else if (a == A_MISS) m_miss = d;
            else if (a == A_STALL) m_stall = d;
        end
        exp_q.push_back('{cyc + 1, m_e, tag});
    endtask

    task automatic idle(input string tag);
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, tag);
    endtask

    task automatic wr(input int a, input int d);
        step(1'b0, 0, 1'b0, 1'b0, 1'b1, a, d, 1'b0, "R10");
    endtask

    task automatic ret(input int c, input bit mi, input bit st, input string tag);
        step(1'b1, c, mi, st, 1'b0, 0, 0, 1'b0, tag);
    endtask

    // reads every count through the select ports while inputs are idle
    task automatic check_counts(input string ctag, input string ptag);
        idle("R8");
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            csel = 3'(c);
            #1;
            chk(ccount == 32'(m_ccnt[c]), ctag, ccount, m_ccnt[c]);
        end
        for (int p = 0; p < 64; p++) begin
            @(negedge clk);
            psel = 6'(p);
            #1;
            chk(pcount == 32'(m_pcnt[p]), ptag, pcount, m_pcnt[p]);
        end
    endtask

    // monitor: compares queued expectations when they fall due
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(longint'(energy) == e.val, e.tag, longint'(energy), e.val);
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_ccnt[i] = 0; end
        for (int i = 0; i < 64; i++) begin m_pair[i] = 0; m_pcnt[i] = 0; end
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: reset state
        #1;
        chk(energy == '0, "R11", energy, 0);
        check_counts("R11", "R11");
        ret(5, 1'b1, 1'b1, "R11"); // all costs zero after reset

        // load costs
        for (int c = 0; c < 8; c++) wr(A_BASE + c, 10 + 3 * c);
        for (int p = 0; p < 64; p++) wr(p, 100 + p);
        wr(A_MISS, 1000);
        wr(A_STALL, 500);
        wr(100, 7777); // unused address, no cost changes (R10)
        wr(127, 4444);

        // R3: fresh window after clear, first retire adds no pair cost
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1, "R9");
        ret(3, 1'b0, 1'b0, "R3");
        ret(3, 1'b0, 1'b0, "R2");
        ret(7, 1'b0, 1'b0, "R2");
        ret(0, 1'b1, 1'b0, "R4");
        ret(1, 1'b0, 1'b1, "R4");
        ret(6, 1'b1, 1'b1, "R4");
        ret(2, 1'b0, 1'b0, "R1");
        // R8: idle cycles keep total and predecessor
        idle("R8"); idle("R8"); idle("R8");
        ret(4, 1'b0, 1'b0, "R8");
        check_counts("R5", "R6");

        // R10: write and retire in the same cycle use the old cost
        step(1'b1, 2, 1'b0, 1'b0, 1'b1, A_BASE + 2, 999, 1'b0, "R10");
        ret(2, 1'b0, 1'b0, "R10");
        step(1'b1, 2, 1'b0, 1'b0, 1'b1, 2 * 8 + 2, 4321, 1'b0, "R10");
        ret(2, 1'b0, 1'b0, "R10");

        // R9: clear together with a retire drops the retire
        step(1'b1, 6, 1'b1, 1'b1, 1'b0, 0, 0, 1'b1, "R9");
        check_counts("R9", "R9");
        ret(6, 1'b0, 1'b0, "R3");
        ret(0, 1'b0, 1'b0, "R2");

        // mixed traffic
        for (int k = 0; k < 300; k++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r == 0) idle("R8");
            else if (r == 1) wr($urandom_range(0, 73), $urandom_range(0, 300));
            else ret($urandom_range(0, 7), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), "R2");
        end
        check_counts("R5", "R6");

        // R7: saturation
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1, "R9");
        wr(A_BASE + 7, 16'hFFFF);
        wr(63, 16'hFFFF);
        wr(A_MISS, 16'hFFFF);
        wr(A_STALL, 16'hFFFF);
        for (int k = 0; k < 8; k++) ret(7, 1'b1, 1'b1, "R7");
        idle("R7");
        @(negedge clk);
        #1;
        chk(longint'(energy) == EMAX, "R7", longint'(energy), EMAX);
        ret(0, 1'b0, 1'b0, "R7");
        idle("R7");
        idle("R7");
        @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule